// File: doc/BRIEF.md
# DVP RGB565 Pixel Capture

This block sits directly on the parallel video port of a camera sensor. It runs entirely on the sensor's pixel clock. On every rising edge it samples the frame-sync line, the line-valid qualifier and the 8-bit data byte. While line-valid is high it joins each pair of consecutive bytes into one 16-bit RGB565 word. The first byte of a pair becomes the upper half of the word.

Each finished word leaves on a single-cycle valid strobe together with its column and line numbers. A start-of-frame tag marks the first pixel after a frame sync, and an end-of-line tag marks the last pixel of a full-width line. A separate pulse reports any line whose pixel count differs from the configured width. The default raster is 1280 x 720, for example at 84 MHz and 30 frames per second.

Capture starts only once the enable input is high and a rising edge of frame sync has been seen, so a partial first frame is never delivered. The output is a valid-only stream with no ready input. The sensor cannot be paused, so the consumer must accept a word in every cycle in which `pixel_valid` is high, and a word that is not taken in that cycle is gone.

Top module: `dvp_rgb565_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pixel_valid`, `frame_first`, `line_last` and `line_len_err` are low.
- R2: Bytes are discarded until `enable` is high and a rising edge of `cam_frame_sync` has been sampled with `enable` high. When `enable` is sampled low, capture stops at once: `pixel_valid` is low in the following cycle. Capture resumes only after a new frame-sync rising edge.
- R3: A byte is taken on a rising clock edge only when `cam_line_valid` is high at that edge. The first byte of a pair is placed in `pixel_data[15:8]` and the second in `pixel_data[7:0]`. `pixel_valid` is high for exactly one cycle, in the cycle after the edge that takes the second byte.
- R4: The pairing restarts with a high byte after any edge where `cam_line_valid` is low, and after every frame-sync rising edge. As a result, a stray odd byte at the end of a line is dropped and the next line begins on a pixel boundary.
- R5: `pix_x` gives the column of the pixel, counted from 0 within its line. `pix_y` gives the line number, counted from 0 within the frame. Both are valid in the same cycle as `pixel_valid`.
- R6: `frame_first` is high together with the first pixel after each frame-sync rising edge, and with no other pixel.
- R7: `line_last` is high together with the pixel whose column is `H_ACTIVE-1`, and with no other pixel.
- R8: When `cam_line_valid` falls during capture, `line_len_err` pulses for one cycle if the line carried fewer or more than `H_ACTIVE` pixels. It does not pulse for a line of exactly `H_ACTIVE` pixels.
- R9: If a frame-sync rising edge and a line-valid falling edge are sampled on the same clock edge, the length check of the ending line is still reported. The counters restart, so the next pixel carries column 0, line 0 and `frame_first`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Sensor pixel clock; all logic samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| cam_frame_sync | input | 1 | Frame sync from the sensor; a rising edge starts a frame |
| cam_line_valid | input | 1 | Line-valid qualifier; bytes count only while it is high |
| cam_byte | input | DATA_W (8) | Sensor data byte |
| pixel_valid | output | 1 | One-cycle strobe for a completed pixel |
| pixel_data | output | 2*DATA_W (16) | RGB565 word, first byte in the upper half |
| pix_x | output | clog2(H_ACTIVE+1) | Column of the pixel |
| pix_y | output | clog2(V_ACTIVE+1) | Line of the pixel |
| frame_first | output | 1 | Tags the first pixel of a frame |
| line_last | output | 1 | Tags the pixel in the last column |
| line_len_err | output | 1 | One-cycle pulse on a line of the wrong length |

## Verification
The two events that can land on the same clock edge are the close of a line (line-valid falling) and the start of a frame (frame-sync rising). The bench provokes this by dropping line-valid and raising frame sync at the same falling clock edge, directly after a short line of five pixels. The result is judged on two points. First, exactly one length-error pulse must appear for the truncated line. Second, the next pixel must carry column 0, line 0 and the start-of-frame tag, which shows that the frame restart took priority over the line-count increment.

// File: rtl/dvp_cap_pkg.sv
package dvp_cap_pkg;
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } byte_phase_e;

  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/dvp_edge_pick.sv
module dvp_edge_pick #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = level & ~prev;
    end else begin : g_fall
      assign hit = ~level & prev;
    end
  endgenerate
endmodule

// File: rtl/dvp_byte_pair.sv
module dvp_byte_pair
  import dvp_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [DATA_W-1:0]     din,
  output logic                  pair_done,
  output logic                  word_stb,
  output logic [2*DATA_W-1:0]   word
);
  byte_phase_e       phase;
  logic [DATA_W-1:0] upper;

  assign pair_done = take && (phase == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HIGH;
      upper    <= '0;
      word     <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= pair_done;
      if (take) begin
        if (phase == PH_HIGH) begin
          upper <= din;
          phase <= PH_LOW;
        end else begin
          word  <= {upper, din};
          phase <= PH_HIGH;
        end
      end else begin
        phase <= PH_HIGH;
      end
    end
  end
endmodule

// File: rtl/dvp_raster_cnt.sv
module dvp_raster_cnt #(
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned V_ACTIVE = 720,
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned Y_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_restart,
  input  logic             line_close,
  input  logic             pair_done,
  output logic [CNT_W-1:0] px,
  output logic [Y_W-1:0]   py,
  output logic             sof,
  output logic             eol,
  output logic             err
);
  localparam logic [CNT_W-1:0] H_FULL = CNT_W'(H_ACTIVE);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_ACTIVE - 1);
  localparam logic [Y_W-1:0]   V_FULL = Y_W'(V_ACTIVE);

  logic [CNT_W-1:0] col;
  logic [Y_W-1:0]   row;
  logic             overrun;
  logic             sof_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      overrun  <= 1'b0;
      sof_pend <= 1'b0;
      px       <= '0;
      py       <= '0;
      sof      <= 1'b0;
      eol      <= 1'b0;
      err      <= 1'b0;
    end else begin
      err <= line_close && ((col != H_FULL) || overrun);
      if (pair_done) begin
        px       <= col;
        py       <= row;
        sof      <= sof_pend;
        eol      <= (col == H_LAST) && !overrun;
        sof_pend <= 1'b0;
        if (col == H_FULL) overrun <= 1'b1;
        else               col     <= col + 1'b1;
      end else begin
        sof <= 1'b0;
        eol <= 1'b0;
      end
      if (frame_restart) begin
        col      <= '0;
        row      <= '0;
        overrun  <= 1'b0;
        sof_pend <= 1'b1;
      end else if (line_close) begin
        col     <= '0;
        overrun <= 1'b0;
        if (row != V_FULL) row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvp_rgb565_capture.sv
module dvp_rgb565_capture
  import dvp_cap_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned V_ACTIVE = 720,
  localparam int unsigned CNT_W   = count_width(H_ACTIVE),
  localparam int unsigned Y_W     = count_width(V_ACTIVE)
) (
  input  logic                pix_clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cam_frame_sync,
  input  logic                cam_line_valid,
  input  logic [DATA_W-1:0]   cam_byte,
  output logic                pixel_valid,
  output logic [2*DATA_W-1:0] pixel_data,
  output logic [CNT_W-1:0]    pix_x,
  output logic [Y_W-1:0]      pix_y,
  output logic                frame_first,
  output logic                line_last,
  output logic                line_len_err
);
  logic fs_rise, lv_fall;
  logic armed, capture_on;
  logic take, pair_done;

  dvp_edge_pick #(.RISING(1'b1)) u_fs_edge (
    .clk(pix_clk), .rst_n(rst_n), .level(cam_frame_sync), .hit(fs_rise)
  );

  dvp_edge_pick #(.RISING(1'b0)) u_lv_edge (
    .clk(pix_clk), .rst_n(rst_n), .level(cam_line_valid), .hit(lv_fall)
  );

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= enable && (armed || fs_rise);
  end

  assign capture_on = armed && enable;
  assign take       = capture_on && cam_line_valid && !fs_rise;

  dvp_byte_pair #(.DATA_W(DATA_W)) u_pair (
    .clk      (pix_clk),
    .rst_n    (rst_n),
    .take     (take),
    .din      (cam_byte),
    .pair_done(pair_done),
    .word_stb (pixel_valid),
    .word     (pixel_data)
  );

  dvp_raster_cnt #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .CNT_W(CNT_W), .Y_W(Y_W)
  ) u_raster (
    .clk          (pix_clk),
    .rst_n        (rst_n),
    .frame_restart(enable && fs_rise),
    .line_close   (capture_on && lv_fall),
    .pair_done    (pair_done),
    .px           (pix_x),
    .py           (pix_y),
    .sof          (frame_first),
    .eol          (line_last),
    .err          (line_len_err)
  );
endmodule

// File: rtl/dvp_rgb565_capture_chk.sv
module dvp_rgb565_capture_chk #(
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned Y_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cam_line_valid,
  input logic             pixel_valid,
  input logic             frame_first,
  input logic             line_last,
  input logic             line_len_err,
  input logic [CNT_W-1:0] pix_x,
  input logic [Y_W-1:0]   pix_y
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pixel_valid && !frame_first && !line_last && !line_len_err)
        else $error("R1 output active in reset");
    end
  end

  assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pixel_valid);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |=> !pixel_valid);

  assert_line_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_line_valid |=> !pixel_valid);

  assert_sof_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_first |-> (pixel_valid && pix_x == '0 && pix_y == '0));

  assert_eol_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |-> (pixel_valid && pix_x == CNT_W'(H_ACTIVE - 1)));

  assert_err_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_len_err |-> !pixel_valid);
endmodule

bind dvp_rgb565_capture dvp_rgb565_capture_chk #(
  .H_ACTIVE(H_ACTIVE), .CNT_W(CNT_W), .Y_W(Y_W)
) u_chk (
  .clk           (pix_clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .cam_line_valid(cam_line_valid),
  .pixel_valid   (pixel_valid),
  .frame_first   (frame_first),
  .line_last     (line_last),
  .line_len_err  (line_len_err),
  .pix_x         (pix_x),
  .pix_y         (pix_y)
);

// File: tb/dvp_rgb565_capture_tb.sv
`timescale 1ns/1ps
module dvp_rgb565_capture_tb;
  localparam int H = 8;
  localparam int V = 4;
  localparam int CW = $clog2(H + 1);
  localparam int YW = $clog2(V + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic enable = 1'b0;
  logic fsync = 1'b0;
  logic lvalid = 1'b0;
  logic [7:0] dbyte = 8'h00;
  logic pv, sof, eol, lerr;
  logic [15:0] pdata;
  logic [CW-1:0] px;
  logic [YW-1:0] py;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dvp_rgb565_capture #(.DATA_W(8), .H_ACTIVE(H), .V_ACTIVE(V)) u_dut (
    .pix_clk(clk), .rst_n(rst_n), .enable(enable),
    .cam_frame_sync(fsync), .cam_line_valid(lvalid), .cam_byte(dbyte),
    .pixel_valid(pv), .pixel_data(pdata), .pix_x(px), .pix_y(py),
    .frame_first(sof), .line_last(eol), .line_len_err(lerr)
  );

  logic [15:0] m_d [0:127];
  int          m_x [0:127];
  int          m_y [0:127];
  bit          m_s [0:127];
  bit          m_e [0:127];
  int m_n = 0;
  int e_n = 0;

  always @(negedge clk) begin
    if (pv && m_n < 128) begin
      m_d[m_n] = pdata; m_x[m_n] = int'(px); m_y[m_n] = int'(py);
      m_s[m_n] = sof;   m_e[m_n] = eol;
      m_n = m_n + 1;
    end
    if (lerr) e_n = e_n + 1;
  end

  function automatic logic [15:0] pat(input int ln, input int i);
    return 16'(ln * 16'h1021 + i * 16'h0313 + 16'hA55A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); lvalid = 1'b1; dbyte = b;
  endtask

  task automatic send_pixels(input int ln, input int npix, input bit extra);
    for (int i = 0; i < npix; i++) begin
      send_byte(pat(ln, i)[15:8]);
      send_byte(pat(ln, i)[7:0]);
    end
    if (extra) send_byte(8'hEE);
  endtask

  task automatic line_gap();
    @(negedge clk); lvalid = 1'b0; dbyte = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_line(input int ln, input int npix, input bit extra);
    send_pixels(ln, npix, extra);
    line_gap();
  endtask

  task automatic fs_pulse();
    @(negedge clk); fsync = 1'b1;
    repeat (3) @(negedge clk);
    fsync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!pv && !sof && !eol && !lerr, "R1 outputs quiet in reset", {pv, sof, eol, lerr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pv && !sof && !eol && !lerr, "R1 outputs quiet after reset", {pv, sof, eol, lerr}, 0);
  endtask

  task automatic t_not_armed();
    int b = m_n;
    enable = 1'b1;
    send_line(0, H, 0);
    chk(m_n == b, "R2 no pixels before frame sync", m_n - b, 0);
    enable = 1'b0;
    fs_pulse();
    send_line(0, H, 0);
    chk(m_n == b, "R2 no pixels while disabled", m_n - b, 0);
  endtask

  task automatic t_full_frame();
    int b = m_n;
    int eb = e_n;
    int bad_d = 0, bad_xy = 0, bad_s = 0, bad_e = 0;
    enable = 1'b1;
    fs_pulse();
    for (int ln = 0; ln < V; ln++) send_line(ln, H, 0);
    chk(m_n - b == H * V, "R3 pixel count of full frame", m_n - b, H * V);
    for (int k = 0; k < H * V; k++) begin
      if (m_d[b + k] != pat(k / H, k % H)) bad_d++;
      if (m_x[b + k] != k % H || m_y[b + k] != k / H) bad_xy++;
      if (m_s[b + k] != (k == 0)) bad_s++;
      if (m_e[b + k] != (k % H == H - 1)) bad_e++;
    end
    chk(bad_d == 0, "R3 pixel words high byte first", bad_d, 0);
    chk(bad_xy == 0, "R5 column and line numbers", bad_xy, 0);
    chk(bad_s == 0, "R6 start-of-frame tag", bad_s, 0);
    chk(bad_e == 0, "R7 end-of-line tag", bad_e, 0);
    chk(e_n == eb, "R8 no error on full lines", e_n - eb, 0);
  endtask

  task automatic t_odd_byte();
    int b = m_n;
    int eb = e_n;
    int bad = 0;
    fs_pulse();
    send_line(0, 3, 1);
    send_line(1, H, 0);
    chk(m_n - b == 3 + H, "R4 pixel count after odd byte", m_n - b, 3 + H);
    for (int i = 0; i < H; i++)
      if (m_d[b + 3 + i] != pat(1, i) || m_y[b + 3 + i] != 1 || m_x[b + 3 + i] != i) bad++;
    chk(bad == 0, "R4 next line realigned", bad, 0);
    chk(e_n - eb == 1, "R8 short line flagged", e_n - eb, 1);
  endtask

  task automatic t_long_line();
    int b = m_n;
    int eb = e_n;
    int ne = 0;
    fs_pulse();
    send_line(0, H + 1, 0);
    chk(m_n - b == H + 1, "R3 long line pixel count", m_n - b, H + 1);
    for (int k = 0; k < H + 1; k++) if (m_e[b + k]) ne++;
    chk(ne == 1 && m_e[b + H - 1], "R7 single end-of-line tag", ne, 1);
    chk(e_n - eb == 1, "R8 long line flagged", e_n - eb, 1);
  endtask

  task automatic t_collision();
    int b = m_n;
    int eb;
    fs_pulse();
    eb = e_n;
    send_pixels(0, 5, 0);
    @(negedge clk); lvalid = 1'b0; fsync = 1'b1;
    repeat (3) @(negedge clk);
    fsync = 1'b0;
    repeat (2) @(negedge clk);
    send_line(0, H, 0);
    chk(e_n - eb == 1, "R9 truncated line still flagged", e_n - eb, 1);
    chk(m_n - b == 5 + H, "R9 pixel count", m_n - b, 5 + H);
    chk(m_x[b + 5] == 0 && m_y[b + 5] == 0, "R9 counters restarted", m_y[b + 5], 0);
    chk(m_s[b + 5] == 1'b1 && m_d[b + 5] == pat(0, 0), "R9 start-of-frame after collision", m_s[b + 5], 1);
  endtask

  task automatic t_enable_drop();
    int b = m_n;
    fs_pulse();
    send_line(0, H, 0);
    chk(m_n - b == H, "R2 capture while enabled", m_n - b, H);
    @(negedge clk); enable = 1'b0;
    send_line(1, H, 0);
    chk(m_n - b == H, "R2 dropped while disabled", m_n - b, H);
    @(negedge clk); enable = 1'b1;
    send_line(2, H, 0);
    chk(m_n - b == H, "R2 re-enable waits for frame sync", m_n - b, H);
    fs_pulse();
    send_line(0, H, 0);
    chk(m_n - b == 2 * H && m_s[b + H], "R2 resumes on new frame", m_n - b, 2 * H);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    t_not_armed();
    t_full_frame();
    t_odd_byte();
    t_long_line();
    t_collision();
    t_enable_drop();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule